// File: doc/BRIEF.md
# Gated Power-of-Two Serial Clock Generator

This block produces the serial clock for a flash interface from a faster base clock. A single 32-bit control register selects the divide ratio and enables the output. The ratio field is one-hot. Each set bit picks a power of two, and an all-zero field passes the base clock straight through. When the enable is cleared, the output is held low so that the downstream logic can idle.

The register sits on a bus clock that is separate from the base clock. Software can therefore read and write it while the serial clock is stopped. Register contents are carried into the base clock domain through a multi-flop synchronizer. The divider adopts a new setting only while its output is low. After the enable is set, a read-only status bit tells software when the output has run long enough to be trusted.

Top module: `flash_clk_gen`

## Requirements
- R1: After reset the control register reads 0x0000_0000, `ser_clk_o` is low and `stable_o` is low.
- R2: The control register decodes only at byte offset 0x110. The enable is bit 0, the stable flag is bit 1 and the ratio select is bits 18:8. Writes to any other offset leave the register unchanged, and reads of any other offset return zero.
- R3: With exactly one select bit k set (0 to 10), the output period is 2^(k+1) base clock periods.
- R4: With the select field all zero and the enable set, the output follows the base clock, which is a ratio of 1.
- R5: With several select bits set, the highest set bit alone fixes the ratio.
- R6: While the enable is 0, `ser_clk_o` stays low and shows no rising edge.
- R7: Bit 1 is read-only, and writes to it have no effect. Bits 31:19 and 7:2 always read as zero.
- R8: After the enable is set, the stable flag (`stable_o` and register bit 1) rises only once the output has made at least 4 rising edges. It then stays set while the enable remains 1.
- R9: Clearing the enable drops the stable flag at the same bus clock edge that the write lands.
- R10: A new ratio or enable value is adopted only while the output is low. No high pulse is ever shortened, so every high pulse lasts a full half period of either the old ratio or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational on addr_i) |
| base_clk_i | input | 1 | Base clock to be divided |
| ser_clk_o | output | 1 | Gated, divided serial clock |
| stable_o | output | 1 | Output settled flag, bus clock domain |

## Verification
The hardest case to reach is a ratio change that arrives while a long high phase of the output is in progress. A careless divider would cut that pulse short. The bench first runs the slowest ratio to stable. It then waits for a rising edge of the output and writes the fastest ratio part-way through the high phase. A pulse-width monitor then requires every high pulse to be exactly either the old half period or the new one. Settle counting is checked on every table entry by counting output rising edges between the enable write and the rise of the stable flag.

// File: rtl/fcg_pkg.sv
`timescale 1ns/1ps
package fcg_pkg;
  localparam int SEL_W   = 11;
  localparam int SEL_LSB = 8;
  localparam int EN_BIT  = 0;
  localparam int STB_BIT = 1;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    sel_t sel;
    logic en;
  } clk_cfg_t;

  localparam int CFG_W = $bits(clk_cfg_t);

  // half period minus one, in base cycles, for the highest set select bit
  function automatic sel_t half_m1(input sel_t sel);
    sel_t m;
    m = '0;
    for (int i = 0; i < SEL_W; i++)
      if (sel[i]) m = sel_t'((1 << i) - 1);
    return m;
  endfunction
endpackage

// File: rtl/fcg_sync.sv
`timescale 1ns/1ps
module fcg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fcg_regs.sv
`timescale 1ns/1ps
module fcg_regs
  import fcg_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] CTRL_OFS    = 12'h110,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              bus_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              stable_base_i,
  output clk_cfg_t          cfg_o,
  output logic              stable_o
);
  clk_cfg_t cfg_q;
  logic     stb_s;
  logic     hit;
  logic     unused_wdata;

  assign hit          = (addr_i == ADDR_W'(CTRL_OFS));
  assign unused_wdata = ^{wdata_i[31:SEL_LSB+SEL_W], wdata_i[SEL_LSB-1:1]};

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i && hit) begin
      cfg_q.sel <= wdata_i[SEL_LSB +: SEL_W];
      cfg_q.en  <= wdata_i[EN_BIT];
    end
  end

  fcg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_stb_sync (
    .clk_i (bus_clk_i),
    .rst_ni(rst_ni),
    .d_i   (stable_base_i),
    .q_o   (stb_s)
  );

  // stale synced flag is masked as soon as enable drops
  assign stable_o = cfg_q.en & stb_s;
  assign cfg_o    = cfg_q;

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[SEL_LSB +: SEL_W] = cfg_q.sel;
      rdata_o[STB_BIT]          = stable_o;
      rdata_o[EN_BIT]           = cfg_q.en;
    end
  end

  // R2
  miss_write_chk: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(cfg_q));

  // R9
  stb_drop_chk: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    $fell(cfg_q.en) |-> !stable_o);
endmodule

// File: rtl/fcg_divider.sv
`timescale 1ns/1ps
module fcg_divider
  import fcg_pkg::*;
#(
  parameter int SETTLE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     base_clk_i,
  input  logic     rst_ni,
  input  clk_cfg_t cfg_i,
  output logic     ser_clk_o,
  output logic     stable_o
);
  localparam int STB_W = $clog2(SETTLE + 1);

  logic [CFG_W-1:0] cfg_raw;
  clk_cfg_t         cfg_s, cfg_s_q, act_q;
  sel_t             cnt_q, hm1;
  logic             div_q, byp_gate_q;
  logic [STB_W-1:0] stb_cnt_q;
  logic             apply, div_mode, byp_mode, tick, wrap;

  fcg_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
    .clk_i (base_clk_i),
    .rst_ni(rst_ni),
    .d_i   (cfg_i),
    .q_o   (cfg_raw)
  );
  assign cfg_s = clk_cfg_t'(cfg_raw);

  assign hm1      = half_m1(act_q.sel);
  assign div_mode = act_q.en && (act_q.sel != '0);
  assign byp_mode = act_q.en && (act_q.sel == '0);
  assign wrap     = (cnt_q == hm1);
  // adopt only a value seen on two consecutive cycles, and only while output low
  assign apply    = (cfg_s == cfg_s_q) && (cfg_s != act_q) && !div_q;
  assign tick     = !apply && ((div_mode && wrap && !div_q) || byp_mode);

  always_ff @(posedge base_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_s_q <= '0;
      act_q   <= '0;
      cnt_q   <= '0;
      div_q   <= 1'b0;
    end else begin
      cfg_s_q <= cfg_s;
      if (apply) begin
        act_q <= cfg_s;
        cnt_q <= '0;
        div_q <= 1'b0;
      end else if (div_mode) begin
        if (wrap) begin
          cnt_q <= '0;
          div_q <= ~div_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
        div_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge base_clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  stb_cnt_q <= '0;
    else if (!act_q.en)                           stb_cnt_q <= '0;
    else if (tick && stb_cnt_q != STB_W'(SETTLE)) stb_cnt_q <= stb_cnt_q + 1'b1;
  end

  // bypass gate moves on the falling edge so the pass-through never chops a pulse
  always_ff @(negedge base_clk_i or negedge rst_ni) begin
    if (!rst_ni) byp_gate_q <= 1'b0;
    else         byp_gate_q <= byp_mode;
  end

  assign ser_clk_o = (base_clk_i & byp_gate_q) | div_q;
  assign stable_o  = (stb_cnt_q == STB_W'(SETTLE));

  // R10
  cfg_hold_chk: assert property (@(posedge base_clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> !$past(div_q));

  // R6
  gate_off_chk: assert property (@(posedge base_clk_i) disable iff (!rst_ni)
    !act_q.en |-> !div_q);

  // R3
  cnt_range_chk: assert property (@(posedge base_clk_i) disable iff (!rst_ni)
    div_mode |-> (cnt_q <= hm1));

  // R8
  settle_bound_chk: assert property (@(posedge base_clk_i) disable iff (!rst_ni)
    stb_cnt_q <= STB_W'(SETTLE));

  // R8
  stable_rise_chk: assert property (@(posedge base_clk_i) disable iff (!rst_ni)
    $rose(stable_o) |-> act_q.en);
endmodule

// File: rtl/flash_clk_gen.sv
`timescale 1ns/1ps
module flash_clk_gen
  import fcg_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] CTRL_OFS    = 12'h110,
  parameter int          SETTLE      = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              bus_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              base_clk_i,
  output logic              ser_clk_o,
  output logic              stable_o
);
  clk_cfg_t cfg;
  logic     stable_base;

  fcg_regs #(
    .ADDR_W     (ADDR_W),
    .CTRL_OFS   (CTRL_OFS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .bus_clk_i    (bus_clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .stable_base_i(stable_base),
    .cfg_o        (cfg),
    .stable_o     (stable_o)
  );

  fcg_divider #(
    .SETTLE     (SETTLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_div (
    .base_clk_i(base_clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .ser_clk_o (ser_clk_o),
    .stable_o  (stable_base)
  );
endmodule

// File: tb/sim_flash_clk_gen.sv
`timescale 1ns/1ps
module sim_flash_clk_gen;
  localparam int NV     = 8;
  localparam int BASE_T = 10;
  localparam logic [11:0] OFS = 12'h110;

  localparam logic [10:0] SEL_TAB [NV] = '{11'h000, 11'h001, 11'h002, 11'h010,
                                           11'h080, 11'h400, 11'h003, 11'h0C1};
  localparam int RATIO_TAB [NV] = '{1, 2, 4, 32, 256, 2048, 4, 256};
  localparam int REQ_TAB   [NV] = '{4, 3, 3, 3, 3, 3, 5, 5};

  logic        bus_clk = 0, base_clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] addr = OFS;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ser_clk, stable;

  int   checks = 0, fails = 0;
  int   edge_cnt = 0;
  int   cyc = 0;
  bit   mon_on = 0;
  time  t_rise = 0;

  always #10 bus_clk = ~bus_clk;
  always #5  base_clk = ~base_clk;

  flash_clk_gen u0 (
    .bus_clk_i (bus_clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i   (wdata), .rdata_o(rdata), .base_clk_i(base_clk),
    .ser_clk_o (ser_clk), .stable_o(stable)
  );

  function automatic string rq(input int n);
    case (n)
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge bus_clk);
    wr_en = 0; addr = OFS;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    addr = a;
    #1 d = rdata;
    addr = OFS;
  endtask

  function automatic logic [31:0] cw(input logic [10:0] sel, input bit en);
    return {13'b0, sel, 7'b0, en};
  endfunction

  task automatic wait_stable(output bit ok);
    ok = 0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge bus_clk);
      if (stable) begin ok = 1; break; end
    end
  endtask

  task automatic period(output longint p);
    time t0;
    @(posedge ser_clk); t0 = $time;
    @(posedge ser_clk); p = longint'($time - t0);
  endtask

  always @(posedge ser_clk) begin
    edge_cnt++;
    t_rise = $time;
  end

  // R10 high pulses must be a whole half period of old or new ratio
  always @(negedge ser_clk) if (mon_on) begin
    longint w;
    w = longint'($time - t_rise);
    chk(w == 10 || w == 10240, "R10", w, 10240);
  end

  always @(posedge bus_clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    longint p;
    bit ok;
    int e0;

    repeat (3) @(negedge bus_clk);
    // R1 reset state, sampled while reset is still asserted
    chk(rdata == 0, "R1", rdata, 0);
    chk(ser_clk == 0 && stable == 0, "R1", {ser_clk, stable}, 0);
    rst_n = 1;
    repeat (50) @(negedge bus_clk);
    chk(edge_cnt == 0, "R1", edge_cnt, 0);
    rd(OFS, d);
    chk(d == 0, "R1", d, 0);

    // R7 read-only and reserved bits
    wr(OFS, 32'hFFFF_FFFE);
    rd(OFS, d);
    chk(d == 32'h0007_FF00, "R7", d, 32'h0007_FF00);
    chk(stable == 0, "R7", stable, 0);

    // R2 other offsets do nothing
    wr(12'h114, 32'h0000_0001);
    rd(OFS, d);
    chk(d == 32'h0007_FF00, "R2", d, 32'h0007_FF00);
    rd(12'h114, d);
    chk(d == 0, "R2", d, 0);

    for (int v = 0; v < NV; v++) begin
      wr(OFS, cw(SEL_TAB[v], 0));
      repeat (1100) @(negedge bus_clk);
      e0 = edge_cnt;
      repeat (100) @(negedge bus_clk);
      // R6 disabled output quiet
      chk(edge_cnt == e0 && ser_clk == 0, "R6", edge_cnt - e0, 0);
      rd(OFS, d);
      chk(d == cw(SEL_TAB[v], 0), "R2", d, cw(SEL_TAB[v], 0));
      @(negedge bus_clk);
      edge_cnt = 0;
      wr(OFS, cw(SEL_TAB[v], 1));
      wait_stable(ok);
      chk(ok, "R8", ok, 1);
      chk(edge_cnt >= 4, "R8", edge_cnt, 4);
      period(p);
      chk(p == longint'(RATIO_TAB[v] * BASE_T), rq(REQ_TAB[v]), p, RATIO_TAB[v] * BASE_T);
      rd(OFS, d);
      chk(d == (cw(SEL_TAB[v], 1) | 32'h2), "R2", d, cw(SEL_TAB[v], 1) | 32'h2);
      chk(stable == 1, "R8", stable, 1);
    end

    // R9 stable drops with the enable write
    wr(OFS, cw(11'h010, 0));
    repeat (1100) @(negedge bus_clk);
    wr(OFS, cw(11'h010, 1));
    wait_stable(ok);
    chk(ok, "R8", ok, 1);
    @(negedge bus_clk);
    addr = OFS; wdata = cw(11'h010, 0); wr_en = 1;
    @(negedge bus_clk);
    wr_en = 0;
    chk(stable == 0, "R9", stable, 0);
    chk(rdata[1] == 0, "R9", rdata[1], 0);

    // R10 change ratio in the middle of a long high phase
    wr(OFS, cw(11'h400, 0));
    repeat (1100) @(negedge bus_clk);
    wr(OFS, cw(11'h400, 1));
    wait_stable(ok);
    chk(ok, "R8", ok, 1);
    mon_on = 1;
    @(posedge ser_clk);
    #1000;
    wr(OFS, cw(11'h001, 1));
    repeat (60) @(posedge ser_clk);
    mon_on = 0;
    period(p);
    chk(p == 20, "R10", p, 20);
    chk(stable == 1, "R8", stable, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule